// File: doc/BRIEF.md
# Prescaled Period Timer with Pulse and Level Outputs

The block is a gated up-counter that advances on one chosen edge of a separate timer-clock input and runs on the system clock. That input is treated as data: it is sampled and edge-detected. It can optionally pass through a two-flop synchroniser together with the gate input. A programmable prescaler divides the qualifying timer edges by any ratio from 1 to 256. The main counter climbs from zero to an active period value and then wraps. The period is written through a buffer, and that buffer reaches the active register only at a wrap or when the timer is switched on. This means a new period never cuts a running cycle short.

Counting happens only while the timer is enabled and the gate input is at its selected active level. That run state can be read as a status bit. It can also be driven onto the timer output in level mode. In pulse mode the same output marks each wrap for one timer clock. When the gate becomes inactive while the timer is enabled, the count is captured and a capture flag is raised. Every wrap raises a zero flag. Both flags stay set until the host writes a one to them.

The host reaches the block through a write strobe with an address and data, and through a combinational read mux. The map is: 0 control, 1 prescaler, 2 period buffer, 3 count (read-only, no atomic guard), 4 capture (read-only), 5 status.

Top module: `ptmr_top`

## Requirements
- R1: After reset, every register reads 0. This covers control, prescaler, period buffer, count, capture and status. The timer output and both interrupt outputs are 0.
- R2: Control bit 1 selects the counting edge of `tclk_in`: 0 counts rising edges, 1 counts falling edges. Edges of the other direction have no effect on the count.
- R3: With prescaler value N (address 1, bits 7:0), the count advances once per N+1 qualifying timer edges.
- R4: The count runs 0, 1, ..., P and then returns to 0, where P is the active period.
- R5: A write to the period buffer (address 2) takes effect only at the next wrap to 0 or when control bit 0 (enable) goes from 0 to 1. Reading address 2 returns the buffer. The count never exceeds the active period.
- R6: Control bit 2 selects the gate's active level: 0 means `gate_in` high is active, 1 means low is active. While the block is not running, timer edges change neither the count nor the prescaler phase.
- R7: Status bit 2 (RUN) reads 1 exactly when enable is 1 and the conditioned gate is active.
- R8: When control bit 4 is 1 (level mode), `tmr_out` follows RUN.
- R9: When control bit 4 is 0 (pulse mode), `tmr_out` goes high at a wrap. It stays high until the next qualifying timer edge.
- R10: A wrap sets status bit 0 (zero flag, `zero_irq`). A change of the gate from active to inactive while enabled copies the count into the capture register (address 4) and sets status bit 1 (capture flag, `cap_irq`).
- R11: Writing 1 to a status flag bit clears it, and writing 0 leaves it alone. If a set event lands in the same cycle as a clearing write, the flag stays set.
- R12: Control bit 3 routes `tclk_in` and `gate_in` through a two-stage synchroniser. The counting result is the same with the bit at 0 or at 1; only the latency differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| tclk_in | input | 1 | Timer clock, sampled as data |
| gate_in | input | 1 | External run gate |
| tmr_out | output | 1 | Pulse or level timer output |
| run | output | 1 | Current run state |
| zero_irq | output | 1 | Sticky zero/wrap flag |
| cap_irq | output | 1 | Sticky capture flag |

## Verification
The two events that can share a cycle are a counter wrap, which sets the zero flag, and a host write that clears that flag. The bench provokes the collision with the synchroniser bypassed and a period of 1. It drives the wrapping timer edge and the clearing write on the same falling system-clock edge, so both land on the next rising edge. It then judges the result: the flag must still read 1, a later clearing write with no event must bring it to 0, and writing 0 must leave it alone. Randomised runs over prescaler, period, edge, gate polarity and sync setting compare count, flags, capture value and RUN against a bench model.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_PRESC  = 3'd1;
    localparam logic [2:0] A_PERIOD = 3'd2;
    localparam logic [2:0] A_COUNT  = 3'd3;
    localparam logic [2:0] A_CAPT   = 3'd4;
    localparam logic [2:0] A_STATUS = 3'd5;

    typedef enum logic {
        OUT_PULSE = 1'b0,
        OUT_LEVEL = 1'b1
    } out_mode_e;

    // bit4 mode, bit3 sync, bit2 gate invert, bit1 falling edge, bit0 enable
    typedef struct packed {
        out_mode_e mode;
        logic      sync_en;
        logic      gate_inv;
        logic      clk_fall;
        logic      enable;
    } ctrl_t;

    typedef struct packed {
        logic run;
        logic cif;
        logic zif;
    } status_t;

    function automatic logic edge_hit(input logic cur, input logic prev, input logic fall);
        return fall ? (!cur && prev) : (cur && !prev);
    endfunction

endpackage

// File: rtl/ptmr_in_cond.sv
module ptmr_in_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tclk_in,
    input  logic gate_in,
    input  logic sync_en,
    input  logic clk_fall,
    input  logic gate_inv,
    output logic tick,
    output logic gate_act,
    output logic gate_end
);
    import ptmr_pkg::*;

    localparam int LAST = SYNC_STAGES - 1;

    logic [1:0] raw;
    logic [1:0] chain [SYNC_STAGES];
    logic [1:0] sel;
    logic       tclk_prev;
    logic       gate_act_q;

    assign raw = {gate_in, tclk_in};

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign sel      = sync_en ? chain[LAST] : raw;
    assign tick     = edge_hit(sel[0], tclk_prev, clk_fall);
    assign gate_act = sel[1] ^ gate_inv;
    assign gate_end = gate_act_q && !gate_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            tclk_prev  <= 1'b0;
            gate_act_q <= 1'b0;
        end else begin
            tclk_prev  <= sel[0];
            gate_act_q <= gate_act;
        end
    end

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            adv,
    input  logic [PS_W-1:0] ratio,
    output logic            step
);
    logic [PS_W-1:0] ps_q;

    assign step = adv && (ps_q >= ratio);

    always_ff @(posedge clk) begin
        if (rst || clear)  ps_q <= '0;
        else if (step)     ps_q <= '0;
        else if (adv)      ps_q <= ps_q + 1'b1;
    end

    AST_PS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv && !clear |=> $stable(ps_q)); // R6

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             tick,
    input  logic [CNT_W-1:0] period_buf,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             pulse
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_act_q;
    logic             pulse_q;

    assign wrap  = step && (cnt_q == per_act_q);
    assign cnt   = cnt_q;
    assign pulse = pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            per_act_q <= '0;
        end else if (load) begin
            cnt_q     <= '0;
            per_act_q <= period_buf;
        end else if (wrap) begin
            cnt_q     <= '0;
            per_act_q <= period_buf;
        end else if (step) begin
            cnt_q     <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) pulse_q <= 1'b0;
        else if (wrap)   pulse_q <= 1'b1;
        else if (tick)   pulse_q <= 1'b0;
    end

    AST_CNT_LE_PERIOD: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= per_act_q); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step && !load |=> $stable(cnt_q)); // R6
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        pulse_q && !tick && !load |=> pulse_q); // R9

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top #(
    parameter int CNT_W       = 16,
    parameter int PS_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             tclk_in,
    input  logic             gate_in,
    output logic             tmr_out,
    output logic             run,
    output logic             zero_irq,
    output logic             cap_irq
);
    import ptmr_pkg::*;

    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t            ctrl_q;
    logic [PS_W-1:0]  ps_q;
    logic [CNT_W-1:0] perbuf_q;
    logic [CNT_W-1:0] cap_q;
    logic             zif_q, cif_q;

    logic             tick, gate_act, gate_end;
    logic             load, step, wrap, pulse;
    logic [CNT_W-1:0] cnt;
    logic             wr_ctrl, wr_stat, cap_evt;
    ctrl_t            ctrl_new;
    status_t          stat;

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_stat  = wr_en && (wr_addr == A_STATUS);
    assign ctrl_new = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign load     = wr_ctrl && ctrl_new.enable && !ctrl_q.enable;

    ptmr_in_cond #(.SYNC_STAGES(SYNC_STAGES)) u_in (
        .clk      (clk),
        .rst      (rst),
        .tclk_in  (tclk_in),
        .gate_in  (gate_in),
        .sync_en  (ctrl_q.sync_en),
        .clk_fall (ctrl_q.clk_fall),
        .gate_inv (ctrl_q.gate_inv),
        .tick     (tick),
        .gate_act (gate_act),
        .gate_end (gate_end)
    );

    assign run = ctrl_q.enable && gate_act;

    ptmr_prescaler #(.PS_W(PS_W)) u_ps (
        .clk   (clk),
        .rst   (rst),
        .clear (!ctrl_q.enable || load),
        .adv   (tick && run),
        .ratio (ps_q),
        .step  (step)
    );

    ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .step       (step),
        .tick       (tick),
        .period_buf (perbuf_q),
        .cnt        (cnt),
        .wrap       (wrap),
        .pulse      (pulse)
    );

    assign cap_evt = ctrl_q.enable && gate_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            ps_q     <= '0;
            perbuf_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:   ctrl_q   <= ctrl_new;
                A_PRESC:  ps_q     <= wr_data[PS_W-1:0];
                A_PERIOD: perbuf_q <= wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            zif_q <= 1'b0;
            cif_q <= 1'b0;
        end else begin
            if (cap_evt) cap_q <= cnt;
            zif_q <= wrap    || (zif_q && !(wr_stat && wr_data[0]));
            cif_q <= cap_evt || (cif_q && !(wr_stat && wr_data[1]));
        end
    end

    assign stat     = '{run: run, cif: cif_q, zif: zif_q};
    assign zero_irq = zif_q;
    assign cap_irq  = cif_q;
    assign tmr_out  = (ctrl_q.mode == OUT_LEVEL) ? run : pulse;

    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = CNT_W'(ctrl_q);
            A_PRESC:  rd_data = CNT_W'(ps_q);
            A_PERIOD: rd_data = perbuf_q;
            A_COUNT:  rd_data = cnt;
            A_CAPT:   rd_data = cap_q;
            A_STATUS: rd_data = CNT_W'(stat);
            default:  rd_data = '0;
        endcase
    end

    AST_ZIF_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        wrap |=> zero_irq); // R10
    AST_CIF_ON_GATE_END: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> cap_irq); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        zero_irq && !wr_stat |=> zero_irq); // R11

endmodule

// File: tb/ptmr_top_tb.sv
module ptmr_top_tb;
    localparam int CLK_P = 10;

    logic        clk = 0, rst = 1;
    logic        wr_en = 0;
    logic [2:0]  wr_addr = 0, rd_addr = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic        tclk_in = 0, gate_in = 0;
    logic        tmr_out, run, zero_irq, cap_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    ptmr_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tclk_in(tclk_in), .gate_in(gate_in),
        .tmr_out(tmr_out), .run(run), .zero_irq(zero_irq), .cap_irq(cap_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tog();
        @(negedge clk);
        tclk_in = ~tclk_in;
        repeat (4) @(negedge clk);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            tog(); tog();
        end
    endtask

    function automatic logic [15:0] mk_ctrl(input bit mode, input bit sy, input bit gi,
                                            input bit fall, input bit en);
        return {11'd0, mode, sy, gi, fall, en};
    endfunction

    function automatic int exp_count(input int edges, input int ps, input int per);
        return (edges / (ps + 1)) % (per + 1);
    endfunction

    function automatic int exp_zif(input int edges, input int ps, input int per);
        return ((edges / (ps + 1)) >= (per + 1)) ? 1 : 0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int ps, per, edges, cnt_exp;
        bit fall, gi, sy;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 register", int'(d), 0);
        end
        chk("R1 tmr_out", int'(tmr_out), 0);
        chk("R1 irqs", int'({zero_irq, cap_irq}), 0);

        // R5/R4/R9 double buffer and pulse
        wr(3'd2, 16'd3);
        gate_in = 1;
        wr(3'd0, mk_ctrl(0, 0, 0, 0, 1));
        cyc(1);
        wr(3'd2, 16'd5);
        cyc(2);
        rd(3'd3, d); chk("R5 count before wrap with old period", int'(d), 3);
        cyc(1);
        rd(3'd3, d); chk("R4 wrap to zero", int'(d), 0);
        chk("R9 pulse after wrap", int'(tmr_out), 1);
        chk("R10 zero flag", int'(zero_irq), 1);
        rd(3'd2, d); chk("R5 buffer readback", int'(d), 5);
        cyc(1);
        chk("R9 pulse cleared by next edge", int'(tmr_out), 0);
        cyc(4);
        rd(3'd3, d); chk("R5 new period reached", int'(d), 5);
        cyc(1);
        rd(3'd3, d); chk("R4 wrap at new period", int'(d), 0);

        // R6 stopped: gate inactive holds count
        cyc(2);
        gate_in = 0;
        repeat (3) @(negedge clk);
        chk("R10 capture flag", int'(cap_irq), 1);
        rd(3'd4, d); chk("R10 capture value", int'(d), 2);
        cyc(3);
        rd(3'd3, d); chk("R6 hold while gated", int'(d), 2);
        chk("R7 run low", int'(run), 0);

        // R2 falling edge
        wr(3'd0, 16'd0);
        wr(3'd5, 16'd3);
        wr(3'd2, 16'd50);
        gate_in = 1;
        wr(3'd0, mk_ctrl(0, 0, 0, 1, 1));
        tog();
        rd(3'd3, d); chk("R2 rising ignored in falling mode", int'(d), 0);
        tog();
        rd(3'd3, d); chk("R2 falling counted", int'(d), 1);

        // R3 prescaler
        wr(3'd0, 16'd0);
        wr(3'd1, 16'd2);
        wr(3'd0, mk_ctrl(0, 0, 0, 0, 1));
        cyc(2);
        rd(3'd3, d); chk("R3 prescale partial", int'(d), 0);
        cyc(1);
        rd(3'd3, d); chk("R3 prescale step", int'(d), 1);

        // R8 level mode
        wr(3'd0, 16'd0);
        wr(3'd0, mk_ctrl(1, 0, 0, 0, 1));
        chk("R8 level high when running", int'(tmr_out), 1);
        chk("R7 run status", int'(run), 1);
        gate_in = 0;
        repeat (2) @(negedge clk);
        chk("R8 level low when gated", int'(tmr_out), 0);
        rd(3'd5, d); chk("R7 status run bit", int'(d[2]), 0);

        // R11 set and clear in the same cycle
        wr(3'd0, 16'd0);
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd1);
        wr(3'd5, 16'd3);
        gate_in = 1;
        wr(3'd0, mk_ctrl(0, 0, 0, 0, 1));
        cyc(1);
        @(negedge clk);
        tclk_in = 1; wr_en = 1; wr_addr = 3'd5; wr_data = 16'd1;
        @(negedge clk);
        wr_en = 0;
        chk("R11 set wins over clear", int'(zero_irq), 1);
        wr(3'd5, 16'd0);
        chk("R11 write 0 keeps flag", int'(zero_irq), 1);
        wr(3'd5, 16'd1);
        chk("R11 write 1 clears", int'(zero_irq), 0);
        tclk_in = 0;
        repeat (4) @(negedge clk);

        // Random runs: R2 R3 R4 R6 R10 R12
        for (int it = 0; it < 16; it++) begin
            ps = $urandom_range(0, 3);
            per = $urandom_range(1, 7);
            fall = 1'($urandom_range(0, 1));
            gi = 1'($urandom_range(0, 1));
            sy = 1'($urandom_range(0, 1));
            edges = $urandom_range(3, 40);
            wr(3'd0, 16'd0);
            gate_in = gi;
            repeat (4) @(negedge clk);
            wr(3'd1, 16'(ps));
            wr(3'd2, 16'(per));
            wr(3'd0, mk_ctrl(0, sy, gi, fall, 1));
            wr(3'd5, 16'd3);
            gate_in = ~gi;
            repeat (4) @(negedge clk);
            cyc(edges);
            cnt_exp = exp_count(edges, ps, per);
            rd(3'd3, d); chk("R3 R4 R12 random count", int'(d), cnt_exp);
            chk("R10 random zero flag", int'(zero_irq), exp_zif(edges, ps, per));
            chk("R7 random run", int'(run), 1);
            gate_in = gi;
            repeat (5) @(negedge clk);
            rd(3'd4, d); chk("R10 random capture", int'(d), cnt_exp);
            chk("R10 random capture flag", int'(cap_irq), 1);
            cyc(2);
            rd(3'd3, d); chk("R6 random hold", int'(d), cnt_exp);
            wr(3'd5, 16'd3);
            rd(3'd5, d); chk("R11 random clear", int'(d), 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule